// File: doc/BRIEF.md
# Host/Controller Byte Mailbox

This block passes single bytes in both directions between a host bus agent and an embedded microcontroller. Each side has its own synchronous register port with a 2-bit offset, write data, read data, a write strobe and a read strobe. The window holds three registers: a shared control/status word at offset 0, the host-to-controller data byte at offset 1, and the controller-to-host data byte at offset 2. A write to a data register raises that direction's "byte waiting" flag. When the opposite side reads the byte, the flag drops.

The host gets a level interrupt request and a matching system-management event whenever the controller has left a byte and the interrupt enable is on. Each direction also carries a 2-bit tag that software defines, which describes what the byte means. A separate combinational helper compares a 16-bit I/O address against the debug port 0x0080. It can be set to ignore address bit 0.

The register ports are plain strobe interfaces and have no back-pressure. A strobe is accepted in every cycle it is high, so no ready signal exists and no strobe can be refused. A read returns its data on the port's read-data output one cycle after the strobe, and that output holds its value until the next read.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, every control bit is 0, both data bytes are 0, and `irq_host` and `smi_evt` are low.
- R2: A host write to offset 1 sets control bit 4 (the host-to-controller flag) from the next cycle. A controller read of offset 1 returns that byte and clears bit 4.
- R3: A controller write to offset 2 sets control bit 5 (the controller-to-host flag) from the next cycle. A host read of offset 2 returns that byte and clears bit 5.
- R4: If a write and a read of the same data register happen in the same cycle, the flag ends up set. The read returns the byte held before that write.
- R5: Reading a data register while its flag is 0 returns the last byte written to it and leaves the flag at 0.
- R6: `irq_host` and `smi_evt` equal control bit 6 AND control bit 5. They fall in the cycle after the host read that clears bit 5.
- R7: A controller write to offset 0 updates bits 7, 6 and 3:2. A host write to offset 0 updates only bits 1:0. Neither side's write changes bits 5:4.
- R8: With control bit 7 at 0, `io_match` is high only when `io_addr` equals exactly 0x0080.
- R9: With control bit 7 at 1, `io_match` ignores `io_addr` bit 0, so 0x0080 and 0x0081 both match and 0x0082 does not.
- R10: The read data at either port appears one cycle after the read strobe. Offset 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Standby-domain reset, active low |
| h_addr | input | 2 | Host register offset |
| h_wdata | input | 8 | Host write byte |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | 8 | Host read byte, registered |
| u_addr | input | 2 | Controller register offset |
| u_wdata | input | 8 | Controller write byte |
| u_wr | input | 1 | Controller write strobe |
| u_rd | input | 1 | Controller read strobe |
| u_rdata | output | 8 | Controller read byte, registered |
| irq_host | output | 1 | Level interrupt request toward the host |
| smi_evt | output | 1 | Management event, same condition as irq_host |
| io_addr | input | 16 | I/O address to compare with the debug port |
| io_match | output | 1 | Debug-port address hit |

## Verification
Every register-side effect takes one clock.
- A flag set or cleared by a strobe, the interrupt level that follows from it, and a read byte are all visible one edge after the strobe cycle.
- `io_match` follows `io_addr` and bit 7 with no clock delay.

The driver raises strobes just after a falling edge and drops them at the next falling edge. The monitor compares a read byte at that second falling edge, popping the expected value that the driver queued. Interrupt and decode checks are sampled at the same falling edges, so no sample sits on an active edge.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam logic [AW-1:0] OFS_CTRL = 2'd0;
  localparam logic [AW-1:0] OFS_H2C  = 2'd1;
  localparam logic [AW-1:0] OFS_C2H  = 2'd2;
  localparam int B_MODE = 7;
  localparam int B_IEN  = 6;
  localparam int B_C2HV = 5;
  localparam int B_H2CV = 4;
  localparam int B_C2HT = 2;
  localparam int B_H2CT = 0;
  localparam int TAGW   = 2;
endpackage

// File: rtl/mbox_dir.sv
module mbox_dir #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put,
  input  logic [DW-1:0] din,
  input  logic          take,
  output logic [DW-1:0] dout,
  output logic          avail
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      avail <= 1'b0;
    end else begin
      if (put) dout <= din;
      if (put) avail <= 1'b1;
      else if (take) avail <= 1'b0;
    end
  end

  // R2 R3 R4: a write always leaves the flag set, even with a concurrent read
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    put |=> avail);
  // R2 R3: a read alone clears the flag
  a_r2_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !put) |=> !avail);
  // R5: an empty slot stays empty without a write
  a_r5_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && !put) |=> (!avail && $stable(dout)));
endmodule

// File: rtl/mbox_p80.sv
module mbox_p80 #(
  parameter int          IOW  = 16,
  parameter logic [IOW-1:0] BASE = 16'h0080
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wide,
  input  logic [IOW-1:0] io_addr,
  output logic           hit
);
  localparam int HI = IOW - 1;

  always_comb begin
    if (wide) hit = (io_addr[HI:1] == BASE[HI:1]);
    else      hit = (io_addr == BASE);
  end

  // R8: exact mode rejects every other address
  a_r8_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && io_addr == (BASE ^ 16'h0001)) |-> !hit);
  // R9: relaxed mode accepts the odd neighbour
  a_r9_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && io_addr == (BASE | 16'h0001)) |-> hit);
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int          IOW      = 16,
  parameter logic [IOW-1:0] DBG_PORT = 16'h0080
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  h_addr,
  input  logic [DW-1:0]  h_wdata,
  input  logic           h_wr,
  input  logic           h_rd,
  output logic [DW-1:0]  h_rdata,
  input  logic [AW-1:0]  u_addr,
  input  logic [DW-1:0]  u_wdata,
  input  logic           u_wr,
  input  logic           u_rd,
  output logic [DW-1:0]  u_rdata,
  output logic           irq_host,
  output logic           smi_evt,
  input  logic [IOW-1:0] io_addr,
  output logic           io_match
);
  logic            mode_q, ien_q;
  logic [TAGW-1:0] c2h_tag_q, h2c_tag_q;
  logic [DW-1:0]   h2c_byte, c2h_byte, ctrl_word;
  logic            h2c_av, c2h_av;
  logic            h2c_put, h2c_take, c2h_put, c2h_take;

  assign h2c_put  = h_wr && (h_addr == OFS_H2C);
  assign h2c_take = u_rd && (u_addr == OFS_H2C);
  assign c2h_put  = u_wr && (u_addr == OFS_C2H);
  assign c2h_take = h_rd && (h_addr == OFS_C2H);

  mbox_dir #(.DW(DW)) h2c_i (
    .clk(clk), .rst_n(rst_n), .put(h2c_put), .din(h_wdata),
    .take(h2c_take), .dout(h2c_byte), .avail(h2c_av));

  mbox_dir #(.DW(DW)) c2h_i (
    .clk(clk), .rst_n(rst_n), .put(c2h_put), .din(u_wdata),
    .take(c2h_take), .dout(c2h_byte), .avail(c2h_av));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      ien_q     <= 1'b0;
      c2h_tag_q <= '0;
      h2c_tag_q <= '0;
    end else begin
      if (u_wr && u_addr == OFS_CTRL) begin
        mode_q    <= u_wdata[B_MODE];
        ien_q     <= u_wdata[B_IEN];
        c2h_tag_q <= u_wdata[B_C2HT +: TAGW];
      end
      if (h_wr && h_addr == OFS_CTRL)
        h2c_tag_q <= h_wdata[B_H2CT +: TAGW];
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_MODE]          = mode_q;
    ctrl_word[B_IEN]           = ien_q;
    ctrl_word[B_C2HV]          = c2h_av;
    ctrl_word[B_H2CV]          = h2c_av;
    ctrl_word[B_C2HT +: TAGW]  = c2h_tag_q;
    ctrl_word[B_H2CT +: TAGW]  = h2c_tag_q;
  end

  function automatic logic [DW-1:0] pick(input logic [AW-1:0] a,
      input logic [DW-1:0] c, input logic [DW-1:0] h2c, input logic [DW-1:0] c2h);
    case (a)
      OFS_CTRL: pick = c;
      OFS_H2C:  pick = h2c;
      OFS_C2H:  pick = c2h;
      default:  pick = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata <= '0;
      u_rdata <= '0;
    end else begin
      if (h_rd) h_rdata <= pick(h_addr, ctrl_word, h2c_byte, c2h_byte);
      if (u_rd) u_rdata <= pick(u_addr, ctrl_word, h2c_byte, c2h_byte);
    end
  end

  assign irq_host = ien_q && c2h_av;
  assign smi_evt  = irq_host;

  mbox_p80 #(.IOW(IOW), .BASE(DBG_PORT)) p80_i (
    .clk(clk), .rst_n(rst_n), .wide(mode_q), .io_addr(io_addr), .hit(io_match));

  // R6: a lone host read of the controller byte drops the interrupt
  a_r6_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (c2h_take && !c2h_put) |=> !irq_host);
  // R6: the interrupt only rises after a controller write
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_host) |-> $past(u_wr));
  // R7: flags never move on a control-register write alone
  a_r7_flags_ro: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_wr && h_addr == OFS_CTRL) && !u_wr && !h_rd && !u_rd && !h2c_put)
      |=> ($stable(h2c_av) && $stable(c2h_av)));
  // R10: read data only moves after a read strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> $stable(h_rdata));
endmodule

// File: tb/mbox_bridge_tb_top.sv
`timescale 1ns/100ps
module mbox_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  h_addr = '0, u_addr = '0;
  logic [7:0]  h_wdata = '0, u_wdata = '0;
  logic        h_wr = 0, h_rd = 0, u_wr = 0, u_rd = 0;
  logic [7:0]  h_rdata, u_rdata;
  logic        irq_host, smi_evt, io_match;
  logic [15:0] io_addr = '0;

  int checks = 0, fails = 0;
  logic [7:0] hq[$], uq[$];
  string      hq_tag[$], uq_tag[$];
  logic       h_seen = 0, u_seen = 0;

  always #2.5 clk = ~clk;

  mbox_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_wr(h_wr), .h_rd(h_rd), .h_rdata(h_rdata),
    .u_addr(u_addr), .u_wdata(u_wdata), .u_wr(u_wr), .u_rd(u_rd), .u_rdata(u_rdata),
    .irq_host(irq_host), .smi_evt(smi_evt), .io_addr(io_addr), .io_match(io_match));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares read data one edge after the strobe
  always @(posedge clk) begin
    h_seen <= h_rd;
    u_seen <= u_rd;
  end
  always @(negedge clk) begin
    if (h_seen && hq.size() > 0) check(hq_tag.pop_front(), {8'h0, h_rdata}, {8'h0, hq.pop_front()});
    if (u_seen && uq.size() > 0) check(uq_tag.pop_front(), {8'h0, u_rdata}, {8'h0, uq.pop_front()});
  end

  // driver: one bus cycle on both sides, queues expected read bytes
  task automatic cyc(input logic hw, input logic hr, input logic [1:0] ha, input logic [7:0] hd,
                     input logic [7:0] hexp, input logic uw, input logic ur, input logic [1:0] ua,
                     input logic [7:0] ud, input logic [7:0] uexp, input string req);
    @(negedge clk);
    h_wr = hw; h_rd = hr; h_addr = ha; h_wdata = hd;
    u_wr = uw; u_rd = ur; u_addr = ua; u_wdata = ud;
    if (hr) begin hq.push_back(hexp); hq_tag.push_back(req); end
    if (ur) begin uq.push_back(uexp); uq_tag.push_back(req); end
    @(negedge clk);
    h_wr = 0; h_rd = 0; u_wr = 0; u_rd = 0;
  endtask

  task automatic hw_(input logic [1:0] a, input logic [7:0] d);
    cyc(1, 0, a, d, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic uw_(input logic [1:0] a, input logic [7:0] d);
    cyc(0, 0, 0, 0, 0, 1, 0, a, d, 0, "");
  endtask
  task automatic hr_(input logic [1:0] a, input logic [7:0] e, input string req);
    cyc(0, 1, a, 0, e, 0, 0, 0, 0, 0, req);
  endtask
  task automatic ur_(input logic [1:0] a, input logic [7:0] e, input string req);
    cyc(0, 0, 0, 0, 0, 0, 1, a, 0, e, req);
  endtask
  task automatic p80(input logic [15:0] a, input logic exp, input string req);
    @(negedge clk); io_addr = a; #1;
    check(req, {15'h0, io_match}, {15'h0, exp});
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {15'h0, irq_host}, 16'h0);
    check("R1 smi", {15'h0, smi_evt}, 16'h0);
    hr_(0, 8'h00, "R1 ctrl");
    hr_(2, 8'h00, "R1 c2h byte");
    ur_(1, 8'h00, "R1 h2c byte");
    ur_(3, 8'h00, "R10 offset3");
    p80(16'h0080, 1, "R8 exact hit");
    p80(16'h0081, 0, "R8 odd miss");
    // R7 control writes
    uw_(0, 8'hFF);
    ur_(0, 8'hCC, "R7 mcu ctrl bits");
    hw_(0, 8'hFF);
    hr_(0, 8'hCF, "R7 host tag bits");
    check("R6 no flag no irq", {15'h0, irq_host}, 16'h0);
    // R9 relaxed decode
    p80(16'h0081, 1, "R9 odd hit");
    p80(16'h0080, 1, "R9 even hit");
    p80(16'h0082, 0, "R9 82 miss");
    p80(16'h0180, 0, "R9 high miss");
    uw_(0, 8'h0C);
    p80(16'h0081, 0, "R8 back to exact");
    // R2 host to controller
    hw_(1, 8'h5A);
    ur_(0, 8'h1F, "R2 flag set");
    ur_(1, 8'h5A, "R2 byte");
    ur_(0, 8'h0F, "R2 flag cleared");
    // R5 read of empty slot
    ur_(1, 8'h5A, "R5 stale byte");
    hr_(0, 8'h0F, "R5 flag still 0");
    // R3 / R6 controller to host
    uw_(2, 8'hA5);
    check("R6 gated off", {15'h0, irq_host}, 16'h0);
    hr_(0, 8'h2F, "R3 flag set");
    uw_(0, 8'h4C);
    check("R6 irq on", {15'h0, irq_host}, 16'h1);
    check("R6 smi on", {15'h0, smi_evt}, 16'h1);
    hr_(2, 8'hA5, "R3 byte");
    check("R6 irq drops", {15'h0, irq_host}, 16'h0);
    hr_(0, 8'h4F, "R3 flag cleared");
    // R4 set over clear, both directions
    cyc(0, 1, 2, 0, 8'hA5, 1, 0, 2, 8'h33, 0, "R4 c2h old byte");
    check("R4 irq stays", {15'h0, irq_host}, 16'h1);
    hr_(0, 8'h6F, "R4 c2h flag kept");
    hr_(2, 8'h33, "R4 c2h new byte");
    cyc(1, 0, 1, 8'h77, 0, 0, 1, 1, 0, 8'h5A, "R4 h2c old byte");
    ur_(0, 8'h5F, "R4 h2c flag kept");
    ur_(1, 8'h77, "R4 h2c new byte");
    repeat (2) @(negedge clk);
    check("queues drained", 16'(hq.size() + uq.size()), 16'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule